// File: doc/BRIEF.md
# Video Capture Write-Address Sequencer

This block steers captured video into frame memory. Each memory word holds four packed pixels, so the block advances its write address once per word, not once per pixel. A packing line buffer offers finished words on `word_valid`. The block takes each word with `word_take`. It then places a write request with the matching address and holds that request until the memory side acknowledges it.

Software loads three settings with a single `arm` pulse: a placement mode, a shift and a base address. After that the block needs no further software action. Capture begins at the first frame sync (`vd`) after arming. Each line sync (`hd`) starts a new line, whose start address is the frame start plus the kept-line index times the line stride. The next frame sync ends the capture and sets `done`, which stays set until the block is armed again. The three placements are full frame, two-way split (lines land on every other memory line, moved by the shift) and four-way split (half the lines and half the words per line, moved by the shift as a quadrant offset).

The controller has five states:
- IDLE: leaves on arm and loads the settings.
- ARMED: waits for frame sync.
- WAIT_HD: waits for the first line sync of the frame.
- LINE: takes words.
- REQ: holds a write until it is acknowledged.

The transitions are:
- arm-accept: IDLE to ARMED.
- frame-open: ARMED to WAIT_HD on `vd`.
- line-open: WAIT_HD or LINE to LINE on `hd`.
- word-issue: LINE to REQ when a word is kept.
- write-done: REQ to LINE on `wr_ack`.
- frame-close: WAIT_HD or LINE to IDLE on `vd`.

Inside WAIT_HD and LINE, frame sync has priority over line sync, and line sync has priority over a word.

Top module: `capture_addr_seq`

## Requirements
- R1: After reset, `wr_req`, `done` and `word_take` are low, and an offered word is not taken.
- R2: `arm` in IDLE loads `cfg_mode`, `cfg_shift` and `cfg_base`. Until the next `vd`, no word is taken and no write is issued, even if `hd` pulses.
- R3: Mode code 0 is full frame. The shift is ignored. Word w of line n (n counted from 0 at the first `hd` of the frame) is written at `cfg_base + n*LINE_WORDS + w`, modulo 2^AW.
- R4: Mode code 1 is two-way split. Word w of line n is written at `cfg_base + cfg_shift + n*2*LINE_WORDS + w`, for w below LINE_WORDS.
- R5: Mode code 2 is four-way split. Only even lines are written, and only their words w below LINE_WORDS/2. The address is `cfg_base + cfg_shift + (n/2)*2*LINE_WORDS + w`. All other words are taken without a write.
- R6: A word offered after a line already received its quota of written words is taken without a write.
- R7: While `wr_req` is high and `wr_ack` is low, `wr_req` stays high, `wr_addr` stays unchanged and no word is taken.
- R8: A `vd` during capture ends it. `done` is high from the next cycle until the next accepted `arm`. After the end, words are not taken and no write is issued.
- R9: Mode code 3 places the image exactly as mode 0 does.
- R10: After the opening `vd`, words are not taken until the first `hd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Load settings and wait for a frame (IDLE only) |
| cfg_mode | input | 2 | Placement: 0 full, 1 two-way split, 2 four-way split, 3 as full |
| cfg_shift | input | AW | Placement offset for the split modes |
| cfg_base | input | AW | Base write address |
| vd | input | 1 | Frame sync, one cycle |
| hd | input | 1 | Line sync, one cycle |
| word_valid | input | 1 | Line buffer offers a packed word |
| word_take | output | 1 | Offered word is consumed this cycle |
| wr_req | output | 1 | Write request to memory |
| wr_addr | output | AW | Write address, valid with `wr_req` |
| wr_ack | input | 1 | Memory accepts the pending write |
| done | output | 1 | Capture finished |

## Verification
`word_take` is combinational. The bench samples it one time unit after a falling edge in the same cycle it offers a word, and the word is consumed at the following rising edge. `wr_req` and its address appear one rising edge after a kept word is taken. The scoreboard compares them at the next falling edge, then waits zero to two cycles before acknowledging, checking at each falling edge that the request and address hold. `done` is registered at the same edge that samples the closing `vd`, so it is checked at the falling edge right after that pulse. Line and frame pulses are only driven when no write is pending.

// File: rtl/cas_pkg.sv
package cas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_WAIT_HD = 3'd2,
        ST_LINE    = 3'd3,
        ST_REQ     = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        MODE_FULL   = 2'd0,
        MODE_SPLIT2 = 2'd1,
        MODE_SPLIT4 = 2'd2,
        MODE_RSVD   = 2'd3
    } cap_mode_t;

endpackage

// File: rtl/cas_cfg.sv
module cas_cfg
    import cas_pkg::*;
#(
    parameter int AW         = 16,
    parameter int LINE_WORDS = 4,
    parameter int CW         = $clog2(LINE_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    cfg_mode,
    input  logic [AW-1:0] cfg_shift,
    input  logic [AW-1:0] cfg_base,
    output logic [AW-1:0] start_addr,
    output logic [AW-1:0] stride,
    output logic [CW-1:0] words_per_line,
    output logic          skip_odd
);
    localparam logic [AW-1:0] ONE_LINE  = AW'(LINE_WORDS);
    localparam logic [AW-1:0] TWO_LINES = AW'(2 * LINE_WORDS);
    localparam logic [CW-1:0] FULL_CNT  = CW'(LINE_WORDS);
    localparam logic [CW-1:0] HALF_CNT  = CW'(LINE_WORDS / 2);

    cap_mode_t     mode_q;
    logic [AW-1:0] shift_q;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_FULL;
            shift_q <= '0;
            base_q  <= '0;
        end else if (load) begin
            mode_q  <= cap_mode_t'(cfg_mode);
            shift_q <= cfg_shift;
            base_q  <= cfg_base;
        end
    end

    always_comb begin
        unique case (mode_q)
            MODE_SPLIT2: begin
                start_addr     = base_q + shift_q;
                stride         = TWO_LINES;
                words_per_line = FULL_CNT;
                skip_odd       = 1'b0;
            end
            MODE_SPLIT4: begin
                start_addr     = base_q + shift_q;
                stride         = TWO_LINES;
                words_per_line = HALF_CNT;
                skip_odd       = 1'b1;
            end
            default: begin
                start_addr     = base_q;
                stride         = ONE_LINE;
                words_per_line = FULL_CNT;
                skip_odd       = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cas_fsm.sv
module cas_fsm
    import cas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic vd,
    input  logic hd,
    input  logic word_valid,
    input  logic word_keep,
    input  logic wr_ack,
    output logic cfg_load,
    output logic frame_start,
    output logic line_start,
    output logic word_accept,
    output logic word_take,
    output logic wr_req,
    output logic done
);
    seq_state_t state_q, state_d;
    logic       cap_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (arm) state_d = ST_ARMED;
            ST_ARMED:   if (vd)  state_d = ST_WAIT_HD;
            ST_WAIT_HD: begin
                if (vd)      state_d = ST_IDLE;
                else if (hd) state_d = ST_LINE;
            end
            ST_LINE: begin
                if (vd)                          state_d = ST_IDLE;
                else if (hd)                     state_d = ST_LINE;
                else if (word_valid && word_keep) state_d = ST_REQ;
            end
            ST_REQ:     if (wr_ack) state_d = ST_LINE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cfg_load    = (state_q == ST_IDLE) && arm;
        frame_start = (state_q == ST_ARMED) && vd;
        cap_end     = ((state_q == ST_WAIT_HD) || (state_q == ST_LINE)) && vd;
        line_start  = ((state_q == ST_WAIT_HD) || (state_q == ST_LINE)) && !vd && hd;
        word_take   = (state_q == ST_LINE) && !vd && !hd && word_valid;
        word_accept = word_take;
        wr_req      = (state_q == ST_REQ);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        done <= 1'b0;
        else if (cfg_load) done <= 1'b0;
        else if (cap_end)  done <= 1'b1;
    end

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);
    assert_no_take_in_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !word_take);
    assert_done_after_vd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(vd));
    assert_armed_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |-> (!word_take && !wr_req));
    assert_wait_hd_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HD) |-> !word_take);

endmodule

// File: rtl/cas_addr_gen.sv
module cas_addr_gen #(
    parameter int AW         = 16,
    parameter int LINE_WORDS = 4,
    parameter int CW         = $clog2(LINE_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          line_start,
    input  logic          word_accept,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] stride,
    input  logic [CW-1:0] words_per_line,
    input  logic          skip_odd,
    input  logic          wr_req,
    input  logic          wr_ack,
    output logic          word_keep,
    output logic [AW-1:0] wr_addr
);
    logic [AW-1:0] next_line;
    logic [AW-1:0] line_addr;
    logic [CW-1:0] word_cnt;
    logic          line_odd;
    logic          line_kept;
    logic          this_kept;

    assign this_kept = !(skip_odd && line_odd);
    assign word_keep = line_kept && (word_cnt < words_per_line);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_line <= '0;
            line_addr <= '0;
            word_cnt  <= '0;
            line_odd  <= 1'b0;
            line_kept <= 1'b0;
            wr_addr   <= '0;
        end else if (frame_start) begin
            next_line <= start_addr;
            word_cnt  <= '0;
            line_odd  <= 1'b0;
            line_kept <= 1'b0;
        end else if (line_start) begin
            line_kept <= this_kept;
            line_odd  <= ~line_odd;
            word_cnt  <= '0;
            if (this_kept) begin
                line_addr <= next_line;
                next_line <= next_line + stride;
            end
        end else if (word_accept && word_keep) begin
            wr_addr  <= line_addr + AW'(word_cnt);
            word_cnt <= word_cnt + 1'b1;
        end
    end

    assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> $stable(wr_addr));

endmodule

// File: rtl/capture_addr_seq.sv
module capture_addr_seq #(
    parameter int AW         = 16,
    parameter int LINE_WORDS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [1:0]    cfg_mode,
    input  logic [AW-1:0] cfg_shift,
    input  logic [AW-1:0] cfg_base,
    input  logic          vd,
    input  logic          hd,
    input  logic          word_valid,
    output logic          word_take,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    input  logic          wr_ack,
    output logic          done
);
    localparam int CW = $clog2(LINE_WORDS + 1);

    logic          cfg_load, frame_start, line_start, word_accept, word_keep, skip_odd;
    logic [AW-1:0] start_addr, stride;
    logic [CW-1:0] words_per_line;

    cas_cfg #(.AW(AW), .LINE_WORDS(LINE_WORDS), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .cfg_mode(cfg_mode), .cfg_shift(cfg_shift), .cfg_base(cfg_base),
        .start_addr(start_addr), .stride(stride),
        .words_per_line(words_per_line), .skip_odd(skip_odd)
    );

    cas_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .vd(vd), .hd(hd),
        .word_valid(word_valid), .word_keep(word_keep), .wr_ack(wr_ack),
        .cfg_load(cfg_load), .frame_start(frame_start), .line_start(line_start),
        .word_accept(word_accept), .word_take(word_take), .wr_req(wr_req),
        .done(done)
    );

    cas_addr_gen #(.AW(AW), .LINE_WORDS(LINE_WORDS), .CW(CW)) u_addr (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .word_accept(word_accept),
        .start_addr(start_addr), .stride(stride),
        .words_per_line(words_per_line), .skip_odd(skip_odd),
        .wr_req(wr_req), .wr_ack(wr_ack),
        .word_keep(word_keep), .wr_addr(wr_addr)
    );

endmodule

// File: tb/capture_addr_seq_test.sv
module capture_addr_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [1:0]    cfg_mode = '0;
    logic [AW-1:0] cfg_shift = '0;
    logic [AW-1:0] cfg_base = '0;
    logic          vd = 1'b0, hd = 1'b0, word_valid = 1'b0, wr_ack = 1'b0;
    logic          word_take, wr_req, done;
    logic [AW-1:0] wr_addr;

    int checks = 0;
    int failures = 0;
    int n_req = 0;
    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    capture_addr_seq #(.AW(AW), .LINE_WORDS(LW)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_mode(cfg_mode),
        .cfg_shift(cfg_shift), .cfg_base(cfg_base), .vd(vd), .hd(hd),
        .word_valid(word_valid), .word_take(word_take), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_ack(wr_ack), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor and memory-side responder.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (wr_req) begin
                logic [AW-1:0] held;
                held = wr_addr;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected write", wr_addr, 0);
                end else begin
                    logic [AW-1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(wr_addr == e, t, wr_addr, e);
                end
                repeat (n_req % 3) begin
                    @(negedge clk);
                    #2;
                    chk(wr_req && wr_addr == held && !word_take, "R7 hold", wr_addr, held);
                end
                n_req++;
                wr_ack = 1'b1;
                @(negedge clk);
                wr_ack = 1'b0;
            end
        end
    end

    task automatic send_word(input string req);
        word_valid = 1'b1;
        for (int i = 0; i < 50; i++) begin
            #1;
            if (word_take) begin
                @(negedge clk);
                word_valid = 1'b0;
                return;
            end
            @(negedge clk);
        end
        word_valid = 1'b0;
        chk(1'b0, req, 0, 1);
    endtask

    task automatic check_no_take(input int n, input string req);
        logic seen;
        seen = 1'b0;
        word_valid = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1;
            if (word_take || wr_req) seen = 1'b1;
            @(negedge clk);
        end
        word_valid = 1'b0;
        chk(!seen, req, seen, 0);
    endtask

    task automatic pulse(input bit is_vd);
        while (wr_req) @(negedge clk);
        if (is_vd) vd = 1'b1; else hd = 1'b1;
        @(negedge clk);
        vd = 1'b0;
        hd = 1'b0;
    endtask

    task automatic run_frame(input logic [1:0] mode, input logic [AW-1:0] base,
                             input logic [AW-1:0] shift, input int lines, input int words);
        int eff;
        eff = (mode == 2'd3) ? 0 : int'(mode);
        cfg_mode = mode; cfg_shift = shift; cfg_base = base; arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
        #1 chk(done == 1'b0, "R8 done cleared by arm", done, 0);
        check_no_take(3, "R2 armed before vd");
        pulse(1'b0);
        check_no_take(2, "R2 hd before vd");
        pulse(1'b1);
        check_no_take(2, "R10 before first hd");
        for (int n = 0; n < lines; n++) begin
            pulse(1'b0);
            for (int w = 0; w < words; w++) begin
                logic [AW-1:0] a;
                bit keep;
                string t;
                if (eff == 0) begin
                    keep = (w < LW); a = base + AW'(n * LW + w);
                    t = (mode == 2'd3) ? "R9 mode 3" : ((w >= LW) ? "R6" : "R3 full");
                end else if (eff == 1) begin
                    keep = (w < LW); a = base + shift + AW'(n * 2 * LW + w); t = "R4 split2";
                end else begin
                    keep = (n % 2 == 0) && (w < LW / 2);
                    a = base + shift + AW'((n / 2) * 2 * LW + w); t = "R5 split4";
                end
                if (keep) begin
                    exp_q.push_back(a);
                    tag_q.push_back(t);
                end
                send_word(keep ? t : "R6 discard not taken");
            end
        end
        while (exp_q.size() != 0 || wr_req) @(negedge clk);
        pulse(1'b1);
        #1 chk(done == 1'b1, "R8 done after vd", done, 1);
        check_no_take(2, "R8 after end");
        pulse(1'b0);
        check_no_take(2, "R8 hd after end");
        chk(done == 1'b1 && exp_q.size() == 0, "R8 done held", done, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(!wr_req && !done && !word_take, "R1 reset outputs", {wr_req, done, word_take}, 0);
        check_no_take(2, "R1 idle no take");
        run_frame(2'd0, 16'd100, 16'd7, 3, LW + 2);
        run_frame(2'd1, 16'd200, 16'd3, 2, LW);
        run_frame(2'd2, 16'h0010, 16'h0040, 4, LW);
        run_frame(2'd3, 16'd500, 16'd9, 2, LW);
        run_frame(2'd0, 16'hFFFE, 16'd0, 1, LW);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule